// File: doc/BRIEF.md
# Multi-Rail Power Sequencer with System Reset

This block sequences three supply rails and a system reset. Each rail has a comparator whose digitized output (`rail_ok_i`) says that the rail is above its threshold. A rail's power-good output is raised only after its comparator has stayed high, without a break, for a qualification delay chosen per rail from four fixed options. The system reset output is held until all three rails are qualified. It is then held for a further delay, chosen from the same four options. If any rail drops, its good output falls at once, the reset is asserted again, and the whole sequence starts over.

A manual reset input passes through a two-flop synchronizer and a length filter. If it is held long enough, it forces every good output low and the reset high. When it is released, each rail and then the reset requalify with their normal delays. All delays count pulses of a millisecond tick input, so simulation can compress time by driving the tick faster.

A volatile fault register records rail failures with clear-on-failure bits. A register-file block can write it and read it back.

Top module: `pwrseq_top`

## Requirements
- R1: A rail's 2-bit delay code (rail i uses `rail_dly_i[2i+1:2i]`) selects a qualification length of 00=100, 01=500, 10=1000 or 11=5000 ticks.
- R2: `rail_good_o[i]` rises on the clock edge of the Nth tick counted while `rail_ok_i[i]` has been continuously high, where N is the selected length. A low cycle on the input restarts the count from zero.
- R3: When `rail_ok_i[i]` is low at a clock edge, `rail_good_o[i]` is low after that edge, and it stays low until the input has requalified.
- R4: Only cycles with `tick_ms_i` high advance a delay count. With no ticks, no output is released.
- R5: `sys_rst_o` is high while any rail is not good. Once all three are good, `sys_rst_o` falls after the length selected by `rst_dly_i`, using the R1 mapping and counted from the cycle after the last rail becomes good. It rises again one cycle after any good output falls.
- R6: A manual reset held high for at least `MR_MIN_CYC` cycles after its two-flop synchronizer drives all good outputs low and `sys_rst_o` high. A shorter pulse has no effect.
- R7: After the manual reset is released, each rail whose input is still high requalifies with its full delay, and the reset follows after its own delay.
- R8: The fault register is writable through `fault_we_i`/`fault_wd_i`. Only bits 0, 2 and 3 are stored, belonging to rails 0, 1 and 2. All other bits read 0.
- R9: A cycle in which `rail_ok_i[i]` is low clears that rail's fault bit. The clear wins over a write in the same cycle, and the bit stays 0 until it is written back to 1.
- R10: A synchronous reset drives `rail_good_o` to 000, `sys_rst_o` to 1 and `fault_o` to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| rail_ok_i | input | 3 | Digitized comparator outputs, 1 = rail above threshold |
| mr_i | input | 1 | Asynchronous manual reset request, active high |
| rail_dly_i | input | 6 | Per-rail qualification delay codes, two bits per rail |
| rst_dly_i | input | 2 | Reset-release delay code |
| fault_we_i | input | 1 | Fault register write strobe |
| fault_wd_i | input | 8 | Fault register write data |
| rail_good_o | output | 3 | Per-rail qualified power-good, active high |
| sys_rst_o | output | 1 | System reset, active high |
| fault_o | output | 8 | Fault register contents |

## Verification
The hardest behaviour to reach from the ports is the collision of a rail failure with a software write to the same fault bit in the same cycle. The bench drops the rail input and raises the write strobe at the same falling edge, so both arrive at the same register edge. A second hard case is a count interrupted partway through. The bench raises a rail, drops it for a single cycle midway through its delay, and then checks that release comes a full delay after the input returns, not the remaining part. The manual-reset filter is reached with a deliberately short pulse followed by a long hold, so both sides of the length threshold are observed.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    localparam int NUM_RAILS  = 3;
    localparam logic [7:0] FAULT_MASK = 8'h0D;

    typedef logic [1:0] dly_sel_t;

    // fault register bit owned by each rail
    function automatic int fault_bit(input int rail);
        case (rail)
            0:       return 0;
            1:       return 2;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/pwrseq_mr_filter.sv
module pwrseq_mr_filter #(
    parameter int MR_MIN_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_i,
    output logic mr_active_o
);
    localparam int CW = $clog2(MR_MIN_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1          <= 1'b0;
            s2          <= 1'b0;
            cnt         <= '0;
            mr_active_o <= 1'b0;
        end else begin
            s1 <= mr_i;
            s2 <= s1;
            if (!s2) begin
                cnt         <= '0;
                mr_active_o <= 1'b0;
            end else if (!mr_active_o) begin
                if (cnt == CW'(MR_MIN_CYC - 1)) mr_active_o <= 1'b1;
                else                             cnt         <= cnt + 1'b1;
            end
        end
    end

    // R6: the filtered request only appears while the synchronized input is high
    p_mr_needs_input_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mr_active_o) |-> $past(s2));
endmodule

// File: rtl/pwrseq_delay_timer.sv
module pwrseq_delay_timer
    import pwrseq_pkg::*;
#(
    parameter int D0 = 100,
    parameter int D1 = 500,
    parameter int D2 = 1000,
    parameter int D3 = 5000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     qual_i,
    input  dly_sel_t sel_i,
    output logic     done_o
);
    localparam int MAXD = (D3 > D2 ? (D3 > D1 ? D3 : D1) : (D2 > D1 ? D2 : D1)) > D0 ?
                          (D3 > D2 ? (D3 > D1 ? D3 : D1) : (D2 > D1 ? D2 : D1)) : D0;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt, target;

    always_comb begin
        case (sel_i)
            2'b00:   target = CW'(D0);
            2'b01:   target = CW'(D1);
            2'b10:   target = CW'(D2);
            default: target = CW'(D3);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !qual_i) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (tick_i && !done_o) begin
            if (cnt + 1'b1 >= target) done_o <= 1'b1;
            else                      cnt    <= cnt + 1'b1;
        end
    end

    // R3: loss of qualification drops the output on the next edge
    p_drop_on_loss_r3: assert property (@(posedge clk) disable iff (rst)
        !qual_i |=> !done_o);
    // R2: once released, the output holds while qualification holds
    p_hold_while_qual_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && qual_i) |=> done_o);
    // R4: release only on a tick
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(tick_i));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int MR_MIN_CYC = 250,
    parameter int D0 = 100,
    parameter int D1 = 500,
    parameter int D2 = 1000,
    parameter int D3 = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms_i,
    input  logic [2:0] rail_ok_i,
    input  logic       mr_i,
    input  logic [5:0] rail_dly_i,
    input  logic [1:0] rst_dly_i,
    input  logic       fault_we_i,
    input  logic [7:0] fault_wd_i,
    output logic [2:0] rail_good_o,
    output logic       sys_rst_o,
    output logic [7:0] fault_o
);
    logic       mr_active;
    logic       rst_done;
    logic [7:0] fail_vec;
    logic [7:0] fault_q;

    pwrseq_mr_filter #(.MR_MIN_CYC(MR_MIN_CYC)) u_mr (
        .clk(clk), .rst(rst), .mr_i(mr_i), .mr_active_o(mr_active)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        pwrseq_delay_timer #(.D0(D0), .D1(D1), .D2(D2), .D3(D3)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_ms_i),
            .qual_i (rail_ok_i[g] && !mr_active),
            .sel_i  (rail_dly_i[2*g +: 2]),
            .done_o (rail_good_o[g])
        );
    end

    pwrseq_delay_timer #(.D0(D0), .D1(D1), .D2(D2), .D3(D3)) u_rst_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_ms_i),
        .qual_i ((&rail_good_o) && !mr_active),
        .sel_i  (rst_dly_i),
        .done_o (rst_done)
    );

    assign sys_rst_o = !rst_done;

    always_comb begin
        fail_vec = '0;
        for (int i = 0; i < NUM_RAILS; i++)
            fail_vec[fault_bit(i)] = !rail_ok_i[i];
    end

    always_ff @(posedge clk) begin
        if (rst)             fault_q <= '0;
        else if (fault_we_i) fault_q <= fault_wd_i & FAULT_MASK & ~fail_vec;
        else                 fault_q <= fault_q & ~fail_vec;
    end

    assign fault_o = fault_q;

    // R5: any rail not good brings reset back on the following edge
    p_rst_follows_rails_r5: assert property (@(posedge clk) disable iff (rst)
        !(&rail_good_o) |=> sys_rst_o);
    // R6: filtered manual reset forces every output to its asserted state
    p_mr_forces_r6: assert property (@(posedge clk) disable iff (rst)
        mr_active |=> (rail_good_o == 3'b000 && sys_rst_o));

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_fchk
        localparam int FB = fault_bit(g);
        // R9: a failing rail always ends the cycle with its fault bit clear
        p_fail_clears_r9: assert property (@(posedge clk) disable iff (rst)
            !rail_ok_i[g] |=> !fault_o[FB]);
    end
endmodule

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MRC = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_ms_i;
    logic [2:0] rail_ok_i;
    logic       mr_i;
    logic [5:0] rail_dly_i;
    logic [1:0] rst_dly_i;
    logic       fault_we_i;
    logic [7:0] fault_wd_i;
    logic [2:0] rail_good_o;
    logic       sys_rst_o;
    logic [7:0] fault_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_top #(.MR_MIN_CYC(MRC)) i_pwrseq_top (
        .clk(clk), .rst(rst), .tick_ms_i(tick_ms_i), .rail_ok_i(rail_ok_i),
        .mr_i(mr_i), .rail_dly_i(rail_dly_i), .rst_dly_i(rst_dly_i),
        .fault_we_i(fault_we_i), .fault_wd_i(fault_wd_i),
        .rail_good_o(rail_good_o), .sys_rst_o(sys_rst_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rails_down();
        rail_ok_i = 3'b000;
        edges(3);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick_ms_i = 1'b1; rail_ok_i = 3'b111; mr_i = 1'b0;
        rail_dly_i = '0; rst_dly_i = '0; fault_we_i = 1'b0; fault_wd_i = '0;
        edges(3);
        chk("R10 good", 32'(rail_good_o), 0);
        chk("R10 rst", 32'(sys_rst_o), 1);
        chk("R10 fault", 32'(fault_o), 0);
        rst = 1'b0;
        rails_down();
    endtask

    // R1/R2: release exactly on the Nth tick for each code
    task automatic t_rail_delay(input logic [1:0] code, input int n);
        rail_dly_i = {3{code}};
        rail_ok_i = 3'b001;
        edges(n - 1);
        chk("R1 before", 32'(rail_good_o[0]), 0);
        edges(1);
        chk("R1 at", 32'(rail_good_o[0]), 1);
        chk("R5 one rail", 32'(sys_rst_o), 1);
        rails_down();
    endtask

    task automatic t_restart();
        rail_dly_i = '0;
        rail_ok_i = 3'b010;
        edges(50);
        rail_ok_i = 3'b000;
        edges(1);
        rail_ok_i = 3'b010;
        edges(99);
        chk("R2 restart before", 32'(rail_good_o[1]), 0);
        edges(1);
        chk("R2 restart at", 32'(rail_good_o[1]), 1);
        rail_ok_i = 3'b000;
        edges(1);
        chk("R3 drop", 32'(rail_good_o[1]), 0);
        rails_down();
    endtask

    task automatic t_tick_gate();
        tick_ms_i = 1'b0;
        rail_ok_i = 3'b100;
        edges(300);
        chk("R4 no tick", 32'(rail_good_o[2]), 0);
        tick_ms_i = 1'b1;
        edges(99);
        chk("R4 before", 32'(rail_good_o[2]), 0);
        edges(1);
        chk("R4 at", 32'(rail_good_o[2]), 1);
        rails_down();
    endtask

    task automatic t_reset_seq();
        rail_dly_i = '0; rst_dly_i = 2'b01;
        rail_ok_i = 3'b111;
        edges(100);
        chk("R5 rails", 32'(rail_good_o), 7);
        edges(499);
        chk("R5 before", 32'(sys_rst_o), 1);
        edges(1);
        chk("R5 release", 32'(sys_rst_o), 0);
        rail_ok_i = 3'b011;
        edges(2);
        chk("R5 brownout", 32'(sys_rst_o), 1);
        rst_dly_i = 2'b00;
        rails_down();
    endtask

    task automatic t_manual();
        rail_ok_i = 3'b111;
        edges(210);
        chk("R7 setup", 32'({rail_good_o, sys_rst_o}), 32'hE);
        mr_i = 1'b1; edges(MRC/2); mr_i = 1'b0;
        edges(10);
        chk("R6 short", 32'({rail_good_o, sys_rst_o}), 32'hE);
        mr_i = 1'b1;
        edges(MRC + 12);
        chk("R6 forced", 32'({rail_good_o, sys_rst_o}), 32'h1);
        mr_i = 1'b0;
        edges(50);
        chk("R7 waiting", 32'({rail_good_o, sys_rst_o}), 32'h1);
        edges(300);
        chk("R7 resequenced", 32'({rail_good_o, sys_rst_o}), 32'hE);
    endtask

    task automatic wr(input logic [7:0] d);
        fault_we_i = 1'b1; fault_wd_i = d;
        edges(1);
        fault_we_i = 1'b0;
    endtask

    task automatic t_fault();
        rail_ok_i = 3'b111;
        wr(8'h0D);
        chk("R8 init", 32'(fault_o), 32'h0D);
        wr(8'hFF);
        chk("R8 mask", 32'(fault_o), 32'h0D);
        rail_ok_i = 3'b101;
        edges(1);
        chk("R9 clear", 32'(fault_o), 32'h09);
        rail_ok_i = 3'b111;
        edges(5);
        chk("R9 sticky", 32'(fault_o), 32'h09);
        rail_ok_i = 3'b110;
        wr(8'h0D);
        chk("R9 priority", 32'(fault_o), 32'h0C);
        rail_ok_i = 3'b111;
        wr(8'h0D);
        chk("R8 rewrite", 32'(fault_o), 32'h0D);
    endtask

    initial begin
        t_reset();
        t_rail_delay(2'b00, 100);
        t_rail_delay(2'b01, 500);
        t_rail_delay(2'b10, 1000);
        t_rail_delay(2'b11, 5000);
        t_restart();
        t_tick_gate();
        t_reset_seq();
        t_manual();
        t_fault();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule